// File: doc/BRIEF.md
# Command-Sequenced I2C Bus Master

This block is a single-master I2C controller in which every bus phase is a separate request from the host. The host asks for a Start, a Repeated Start or a Stop with one-cycle command strobes. It sends a byte by handing it over on a valid/ready transmit port, and it fetches a byte by issuing a receive command. The received byte is then offered on a valid/ready output port. The block generates every SCL pulse itself. A quarter-bit tick from a reload counter paces each phase, and the reload value is a host input.

When any phase finishes, the block sets one shared completion flag, which stays set until the host clears it. For a byte, the flag is set at the end of the ninth SCL clock. In a transmitted byte, the slave's response on the ninth clock is kept in an acknowledge-status bit. A command that arrives while a phase is running, or in a bus state where it makes no sense, is dropped and sets a collision bit. The host builds the address byte itself: seven address bits, then a direction bit that is 0 for a write and 1 for a read.

Back-pressure rules: a transmit byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the bus is owned and no phase is running. A received byte stays on `rx_data` with `rx_valid` high until the host raises `rx_ready`. No further receive is accepted while a byte is waiting.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0), and `busy`, `done_flag`, `wcol`, `ack_stat`, `rx_valid` and `tx_ready` are all 0.
- R2: A Start from the idle bus pulls SDA low while SCL is released, then pulls SCL low. `done_flag` rises 4*(N+1) clock edges after the accepting edge, where N is `brg_reload`, and the bus is then owned (`tx_ready`=1).
- R3: A transmitted byte goes out MSB first as 8 SCL clocks. On a ninth clock SDA is released and sampled into `ack_stat` (1 means not acknowledged). `done_flag` rises 36*(N+1) edges after the handshake edge.
- R4: A receive command clocks in 8 bits MSB first. On the ninth clock the master drives SDA from `rx_nack` (0 pulls low to acknowledge). `done_flag` rises 36*(N+1) edges after acceptance, together with `rx_valid` and the byte on `rx_data`.
- R5: `rx_valid` and `rx_data` hold until `rx_ready` is high. A receive command while `rx_valid` is set is refused and sets `wcol`.
- R6: A Repeated Start while the bus is owned produces a new Start condition with no Stop in between, and the bus stays owned.
- R7: A Stop drives SDA from low to released while SCL is released, leaves both lines released, sets `done_flag` after 4*(N+1) edges and drops `tx_ready`.
- R8: Within a byte, SCL is released for 2*(N+1) clocks and pulled low for 2*(N+1) clocks per bit. SDA changes only while SCL is low.
- R9: A command strobe given while `busy`, a Start while the bus is owned, or a Repeated Start or Stop while it is not owned is ignored and sets `wcol`. Priority when several strobes are high is Start, Repeated Start, Stop, receive.
- R10: `done_flag` and `wcol` stay set until `status_clr` is high for a cycle, which clears both.
- R11: A `tx_valid` while `tx_ready` is low has no effect. A command strobe in the same cycle as a transmit handshake is refused with `wcol`, and the byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_reload | input | BRG_W | Quarter-bit reload value N (quarter = N+1 clocks) |
| cmd_start | input | 1 | Start condition request |
| cmd_rstart | input | 1 | Repeated Start request |
| cmd_stop | input | 1 | Stop condition request |
| cmd_rx | input | 1 | Receive-one-byte request |
| rx_nack | input | 1 | Ninth-bit value for the requested receive (1 = no acknowledge) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be taken |
| tx_data | input | DW | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | DW | Received byte |
| status_clr | input | 1 | Clears completion and collision flags |
| done_flag | output | 1 | Sticky phase-complete flag |
| wcol | output | 1 | Sticky command-collision flag |
| ack_stat | output | 1 | Ninth bit sampled in the last transmitted byte |
| busy | output | 1 | A phase is in progress |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Level seen on the SDA line |

## Verification
Each result is due a fixed number of clock edges after the edge that accepts the request: 4*(N+1) for Start, Repeated Start and Stop, and 36*(N+1) for either kind of byte. The collision bit and `busy` follow one edge after a strobe. The bench drives a request, counts rising edges from the accepting edge and samples 1 ns after each edge until `done_flag` appears, then compares that count with the formula. Bus-level results (bytes on the wire, ninth bits, Start and Stop counts, SCL high and low run lengths) come from monitors that watch the open-drain lines and are read only after the completion flag.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_STOP   = 3'd3,
    OP_TX     = 3'd4,
    OP_RX     = 3'd5
  } op_e;

  // Line pattern {scl_release, sda_release} for each quarter of a bus condition.
  function automatic logic [1:0] cond_lines(op_e op, logic [1:0] step);
    logic [1:0] r;
    r = 2'b11;
    case (op)
      OP_START: begin
        case (step)
          2'd0:    r = 2'b11;
          2'd3:    r = 2'b00;
          default: r = 2'b10;
        endcase
      end
      OP_RSTART: begin
        case (step)
          2'd0:    r = 2'b01;
          2'd1:    r = 2'b11;
          2'd2:    r = 2'b10;
          default: r = 2'b00;
        endcase
      end
      OP_STOP: begin
        case (step)
          2'd0:    r = 2'b00;
          2'd3:    r = 2'b11;
          default: r = 2'b10;
        endcase
      end
      default: r = 2'b11;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2cm_brg.sv
`timescale 1ns/1ps
module i2cm_brg #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [BRG_W-1:0] reload,
  output logic             tick
);
  logic [BRG_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - BRG_W'(1);
    end
  end
endmodule

// File: rtl/i2cm_sync.sv
`timescale 1ns/1ps
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r <= '1;
    else        r <= {r[STAGES-2:0], din};
  end

  assign dout = r[STAGES-1];
endmodule

// File: rtl/i2cm_shreg.sv
`timescale 1ns/1ps
module i2cm_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          sin,
  output logic          msb,
  output logic [DW-1:0] val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val <= '0;
    else if (load)  val <= load_val;
    else if (shift) val <= {val[DW-2:0], sin};
  end

  assign msb = val[DW-1];
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  op_e  go_op,
  input  logic go_sda,
  input  logic go_ack_n,
  input  logic nxt_bit,
  output logic busy,
  output logic owned,
  output logic scl_rel,
  output logic sda_rel,
  output logic sample,
  output logic sample_ack,
  output logic fin,
  output op_e  cur_op
);
  localparam int BW = $clog2(DW + 1);

  logic [1:0]    qtr;
  logic [BW-1:0] bitn;
  logic          ack_n_q;
  logic          is_byte;
  logic          last_q;

  assign is_byte    = (cur_op == OP_TX) || (cur_op == OP_RX);
  assign sample     = busy && tick && is_byte && (qtr == 2'd2);
  assign sample_ack = (bitn == BW'(DW));
  assign last_q     = (qtr == 2'd3) && (!is_byte || bitn == BW'(DW));
  assign fin        = busy && tick && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      owned   <= 1'b0;
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
      qtr     <= 2'd0;
      bitn    <= '0;
      ack_n_q <= 1'b1;
      cur_op  <= OP_NONE;
    end else if (go && !busy) begin
      busy    <= 1'b1;
      cur_op  <= go_op;
      qtr     <= 2'd0;
      bitn    <= '0;
      ack_n_q <= go_ack_n;
      if (go_op == OP_TX || go_op == OP_RX) begin
        scl_rel <= 1'b0;
        sda_rel <= go_sda;
      end else begin
        {scl_rel, sda_rel} <= cond_lines(go_op, 2'd0);
      end
    end else if (busy && tick) begin
      if (last_q) begin
        busy  <= 1'b0;
        owned <= (cur_op != OP_STOP);
      end else if (!is_byte) begin
        qtr <= qtr + 2'd1;
        {scl_rel, sda_rel} <= cond_lines(cur_op, qtr + 2'd1);
      end else begin
        qtr <= qtr + 2'd1;
        case (qtr)
          2'd0: scl_rel <= 1'b1;
          2'd2: scl_rel <= 1'b0;
          2'd3: begin
            bitn <= bitn + BW'(1);
            if (bitn == BW'(DW - 1))
              sda_rel <= (cur_op == OP_RX) ? ack_n_q : 1'b1;
            else
              sda_rel <= (cur_op == OP_RX) ? 1'b1 : nxt_bit;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int BRG_W     = 8,
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             cmd_start,
  input  logic             cmd_rstart,
  input  logic             cmd_stop,
  input  logic             cmd_rx,
  input  logic             rx_nack,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [DW-1:0]    rx_data,
  input  logic             status_clr,
  output logic             done_flag,
  output logic             wcol,
  output logic             ack_stat,
  output logic             busy,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  op_e           pick_op;
  op_e           go_op;
  op_e           cur_op;
  logic          legal;
  logic          owned;
  logic          tx_fire;
  logic          cmd_ok;
  logic          cmd_bad;
  logic          go;
  logic          tick;
  logic          scl_rel;
  logic          sda_rel;
  logic          sample;
  logic          sample_ack;
  logic          seq_fin;
  logic          sda_s;
  logic          sh_msb;
  logic [DW-1:0] sh_val;

  // Strobe priority: start, repeated start, stop, receive.
  always_comb begin
    pick_op = OP_NONE;
    if (cmd_start)       pick_op = OP_START;
    else if (cmd_rstart) pick_op = OP_RSTART;
    else if (cmd_stop)   pick_op = OP_STOP;
    else if (cmd_rx)     pick_op = OP_RX;
  end

  always_comb begin
    case (pick_op)
      OP_START:          legal = !busy && !owned;
      OP_RSTART, OP_STOP: legal = !busy && owned;
      OP_RX:             legal = !busy && owned && !rx_valid;
      default:           legal = 1'b0;
    endcase
  end

  assign tx_ready = !busy && owned;
  assign tx_fire  = tx_valid && tx_ready;
  assign cmd_ok   = (pick_op != OP_NONE) && legal && !tx_fire;
  assign cmd_bad  = (pick_op != OP_NONE) && (!legal || tx_fire);
  assign go       = tx_fire || cmd_ok;
  assign go_op    = tx_fire ? OP_TX : pick_op;

  i2cm_brg #(.BRG_W(BRG_W)) brg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .reload (brg_reload),
    .tick   (tick)
  );

  i2cm_sync #(.STAGES(SYNC_STGS)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sda_i),
    .dout  (sda_s)
  );

  i2cm_shreg #(.DW(DW)) shreg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_fire || (cmd_ok && pick_op == OP_RX)),
    .load_val (tx_fire ? tx_data : {DW{1'b1}}),
    .shift    (sample && !sample_ack),
    .sin      (sda_s),
    .msb      (sh_msb),
    .val      (sh_val)
  );

  i2cm_seq #(.DW(DW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .go         (go),
    .go_op      (go_op),
    .go_sda     (tx_fire ? tx_data[DW-1] : 1'b1),
    .go_ack_n   (rx_nack),
    .nxt_bit    (sh_msb),
    .busy       (busy),
    .owned      (owned),
    .scl_rel    (scl_rel),
    .sda_rel    (sda_rel),
    .sample     (sample),
    .sample_ack (sample_ack),
    .fin        (seq_fin),
    .cur_op     (cur_op)
  );

  assign scl_oe = !scl_rel;
  assign sda_oe = !sda_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      wcol      <= 1'b0;
      ack_stat  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (seq_fin)         done_flag <= 1'b1;
      else if (status_clr) done_flag <= 1'b0;

      if (cmd_bad)         wcol <= 1'b1;
      else if (status_clr) wcol <= 1'b0;

      if (sample && sample_ack && cur_op == OP_TX) ack_stat <= sda_s;

      if (seq_fin && cur_op == OP_RX) begin
        rx_valid <= 1'b1;
        rx_data  <= sh_val;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cm_chk.sv
`timescale 1ns/1ps
module i2cm_chk
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          busy,
  input logic          done_flag,
  input logic          wcol,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          tx_ready,
  input logic          fin,
  input op_e           cur_op,
  input logic          cmd_bad
);
  logic in_byte;
  assign in_byte = busy && (cur_op == OP_TX || cur_op == OP_RX);

  // R8: data line held while the clock line is released inside a byte
  a_r8_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R10: a completed phase leaves the flag set
  a_r10_fin_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_flag);

  // R9: refused command leaves the collision bit set
  a_r9_bad_sets_wcol: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> wcol);

  // R5: pending received byte is held under back-pressure
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11: transmit handshake only between phases
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy);

  // R7: both lines released once a Stop completes
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cur_op == OP_STOP) |=> (!scl_oe && !sda_oe && !tx_ready));
endmodule

bind i2c_cmd_master i2cm_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .busy      (busy),
  .done_flag (done_flag),
  .wcol      (wcol),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .tx_ready  (tx_ready),
  .fin       (seq_fin),
  .cur_op    (cur_op),
  .cmd_bad   (cmd_bad)
);

// File: tb/i2c_cmd_master_tb.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
  localparam int K_START = 0, K_RSTART = 1, K_STOP = 2, K_TX = 3, K_RX = 4;
  // fields: [17] read, [16:10] address, [9:2] data, [1] slave acks, [0] master nack
  localparam logic [17:0] VEC [4] = '{
    {1'b0, 7'h50, 8'hA5, 1'b1, 1'b0},
    {1'b0, 7'h2B, 8'h00, 1'b0, 1'b0},
    {1'b1, 7'h68, 8'h3C, 1'b1, 1'b1},
    {1'b1, 7'h11, 8'hC3, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] brg_reload = 8'd2;
  logic cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rx = 0, rx_nack = 0;
  logic tx_valid = 0, rx_ready = 0, status_clr = 0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, done_flag, wcol, ack_stat, busy, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic scl_line, sda_line, slave_pull;

  int checks = 0, errors = 0;
  int start_cnt = 0, stop_cnt = 0, mcnt = 0, cnt_l = 0;
  logic [7:0] msh = 0, mon_byte = 0, sbyte = 0;
  logic mon_ack = 0, slave_rd = 0, slave_ack = 1;
  logic prev_scl = 1;
  int run_len = 1, hi_len = 0, lo_len = 0;

  always #2 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slave_pull);
  assign slave_pull = slave_rd ? ((cnt_l < 8) ? ~sbyte[7 - cnt_l] : 1'b0)
                               : ((cnt_l == 8) && slave_ack);

  i2c_cmd_master dut_i (
    .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_rx(cmd_rx), .rx_nack(rx_nack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .status_clr(status_clr), .done_flag(done_flag), .wcol(wcol),
    .ack_stat(ack_stat), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_i(sda_line)
  );

  // bus monitor and slave model
  always @(negedge sda_line) if (scl_line) begin start_cnt++; mcnt = 0; cnt_l = 0; end
  always @(posedge sda_line) if (scl_line) stop_cnt++;
  always @(posedge scl_line) begin
    if (mcnt < 8) msh = {msh[6:0], sda_line};
    if (mcnt == 7) mon_byte = msh;
    if (mcnt == 8) mon_ack = sda_line;
    mcnt = (mcnt == 8) ? 0 : mcnt + 1;
  end
  always @(negedge scl_line) cnt_l = mcnt;

  always @(posedge clk) begin
    if (scl_line == prev_scl) run_len <= run_len + 1;
    else begin
      if (prev_scl) hi_len <= run_len; else lo_len <= run_len;
      run_len <= 1;
    end
    prev_scl <= scl_line;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input int kind, input logic [7:0] d, input logic nk, output int n);
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0;
    case (kind)
      K_START:  cmd_start = 1;
      K_RSTART: cmd_rstart = 1;
      K_STOP:   cmd_stop = 1;
      K_TX:     begin tx_valid = 1; tx_data = d; end
      default:  begin cmd_rx = 1; rx_nack = nk; end
    endcase
    @(posedge clk); #1;
    {cmd_start, cmd_rstart, cmd_stop, cmd_rx, tx_valid} = '0;
    n = 0;
    while (!done_flag) begin @(posedge clk); #1; n++; end
  endtask

  task automatic pulse_cmd(input int kind);
    @(negedge clk);
    case (kind)
      K_START:  cmd_start = 1;
      K_RSTART: cmd_rstart = 1;
      K_STOP:   cmd_stop = 1;
      default:  cmd_rx = 1;
    endcase
    @(posedge clk); #1;
    {cmd_start, cmd_rstart, cmd_stop, cmd_rx} = '0;
  endtask

  initial begin
    #(4 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, s0, p0, q;
    repeat (3) @(posedge clk);
    #1;
    check("R1 scl_oe", scl_oe, 0);   check("R1 sda_oe", sda_oe, 0);
    check("R1 busy", busy, 0);       check("R1 done", done_flag, 0);
    check("R1 wcol", wcol, 0);       check("R1 ack", ack_stat, 0);
    check("R1 rx_valid", rx_valid, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 tx_ready", tx_ready, 0);

    // R11: offered byte with no owned bus has no effect
    @(negedge clk) tx_valid = 1; tx_data = 8'h5A;
    repeat (5) @(posedge clk);
    #1; check("R11 busy stays low", busy, 0);
    check("R11 bus quiet", scl_line, 1);
    @(negedge clk) tx_valid = 0;

    q = brg_reload + 1;
    for (int i = 0; i < 4; i++) begin
      logic rd; logic [7:0] dat; logic sak, mnk;
      rd = VEC[i][17]; dat = VEC[i][9:2]; sak = VEC[i][1]; mnk = VEC[i][0];
      slave_ack = sak;
      s0 = start_cnt; p0 = stop_cnt;
      run_op(K_START, 0, 0, n);
      check("R2 start cycles", n, 4 * q);
      check("R2 start seen", start_cnt, s0 + 1);
      check("R2 owned", tx_ready, 1);
      run_op(K_TX, {VEC[i][16:10], rd}, 0, n);
      check("R3 address on wire", mon_byte, {VEC[i][16:10], rd});
      check("R3 byte cycles", n, 36 * q);
      check("R3 ack_stat", ack_stat, !sak);
      if (!rd) begin
        run_op(K_TX, dat, 0, n);
        check("R3 data on wire", mon_byte, dat);
        check("R3 ack_stat data", ack_stat, !sak);
      end else begin
        sbyte = dat; slave_rd = 1;
        run_op(K_RX, 0, mnk, n);
        check("R4 rx cycles", n, 36 * q);
        check("R4 rx_valid", rx_valid, 1);
        check("R4 rx_data", rx_data, dat);
        check("R4 master ninth bit", mon_ack, mnk);
        slave_rd = 0;
        @(negedge clk) rx_ready = 1;
        @(negedge clk) rx_ready = 0;
        check("R5 taken", rx_valid, 0);
      end
      run_op(K_STOP, 0, 0, n);
      check("R7 stop cycles", n, 4 * q);
      check("R7 stop seen", stop_cnt, p0 + 1);
      check("R7 lines released", {scl_oe, sda_oe}, 2'b00);
      check("R7 tx_ready low", tx_ready, 0);
    end

    // R8: clock high/low lengths with a different reload
    brg_reload = 8'd5; q = 6; slave_ack = 1;
    run_op(K_START, 0, 0, n);
    run_op(K_TX, 8'h96, 0, n);
    check("R8 byte cycles", n, 36 * q);
    check("R8 scl high", hi_len, 2 * q);
    check("R8 scl low", lo_len, 2 * q);

    // R10: flag stays set until cleared
    repeat (10) @(posedge clk);
    #1; check("R10 done held", done_flag, 1);

    // R9: stop during a byte is refused
    p0 = stop_cnt;
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0; tx_valid = 1; tx_data = 8'h0F;
    @(posedge clk); #1; tx_valid = 0;
    pulse_cmd(K_STOP);
    check("R9 wcol on busy", wcol, 1);
    while (!done_flag) begin @(posedge clk); #1; end
    check("R9 stop not issued", stop_cnt, p0);
    check("R9 still owned", tx_ready, 1);
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0;
    #1; check("R10 cleared done", done_flag, 0);
    check("R10 cleared wcol", wcol, 0);

    // R9: start while owned is refused
    s0 = start_cnt;
    pulse_cmd(K_START);
    check("R9 wcol start owned", wcol, 1);
    check("R9 no busy", busy, 0);
    repeat (4) @(posedge clk);
    #1; check("R9 no start", start_cnt, s0);

    // R6: repeated start keeps ownership
    s0 = start_cnt; p0 = stop_cnt;
    run_op(K_RSTART, 0, 0, n);
    check("R6 rstart cycles", n, 4 * q);
    check("R6 new start", start_cnt, s0 + 1);
    check("R6 no stop", stop_cnt, p0);
    check("R6 owned", tx_ready, 1);

    // R5: held received byte and refused second receive
    sbyte = 8'h69; slave_rd = 1;
    run_op(K_RX, 0, 1, n);
    slave_rd = 0;
    repeat (6) @(posedge clk);
    #1; check("R5 held valid", rx_valid, 1);
    check("R5 held data", rx_data, 8'h69);
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0;
    pulse_cmd(K_RX);
    check("R5 wcol on pending", wcol, 1);
    check("R5 no receive", busy, 0);
    @(negedge clk) rx_ready = 1;
    @(negedge clk) rx_ready = 0;
    check("R5 released", rx_valid, 0);

    // R11: strobe together with transmit handshake
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0; tx_valid = 1; tx_data = 8'hE1; cmd_stop = 1;
    @(posedge clk); #1; tx_valid = 0; cmd_stop = 0;
    check("R11 byte taken", busy, 1);
    check("R11 wcol", wcol, 1);
    p0 = stop_cnt;
    while (!done_flag) begin @(posedge clk); #1; end
    check("R11 byte on wire", mon_byte, 8'hE1);
    check("R11 no stop", stop_cnt, p0);
    run_op(K_STOP, 0, 0, n);
    check("R7 final stop", stop_cnt, p0 + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule